// File: doc/BRIEF.md
# Warp Barrier Synchronizer

This unit keeps a small bank of named synchronization points for the warps of one core. A warp that reaches a synchronization instruction presents an arrival: a 32-bit barrier identifier, the number of participants it expects, and its own warp number. The unit stalls the arriving warp and records it in that barrier's arrival set. When enough warps have gathered, the stall is lifted for all of them together.

Two kinds of barrier share the bank. A local barrier releases once its arrival count reaches the expected count, and the unit then returns a resume mask naming every gathered warp. A global barrier releases once every currently active warp of the core has arrived. The unit does not resume those warps itself. It issues a request, carrying the barrier index, the expected count and the core number, to a cross-core synchronizer outside this block, and it forgets the arrivals.

Several arrival lanes are accepted in every cycle. Arrivals are qualified by a valid bit alone and are never back-pressured: the unit takes every valid arrival in the cycle it is presented. The resume mask and the global request are single-cycle pulses with no handshake. The consumer must take them in the cycle they appear.

Top module: `warp_barrier`

## Requirements
- R1: An arrival whose expected count is 0 or 1 passes straight through. It asserts no stall, raises no error and leaves every arrival set unchanged.
- R2: A valid arrival with expected count of at least 2 and an in-range index asserts `suspend` for its lane in the same cycle.
- R3: Bit 31 of the barrier identifier selects global mode when set and local mode when clear. Bits 1:0 (the low log2(NUM_BARRIERS) bits) select the barrier. A global barrier does not release on its expected count.
- R4: In local mode, when the number of recorded warps equals the expected count, `resume_mask` carries exactly the recorded warps (bit n = warp n) for one cycle, in the cycle after the completing arrival.
- R5: A barrier's arrival set is empty after it releases, so the next arrivals start a fresh gathering.
- R6: In global mode, when the number of recorded warps equals the number of set bits of `active_warps`, `gbar_req` bit b pulses for one cycle in the next cycle. `gbar_count[b]` holds the expected count and `gbar_core` holds the core number, and `resume_mask` stays clear for those warps.
- R7: An arrival with expected count of at least 2 whose bits 30:0 are at or above NUM_BARRIERS raises `bar_err` in the same cycle. It does not stall and it touches no barrier.
- R8: Arrivals on several lanes for the same barrier in one cycle are all recorded before the completion test. The expected count and mode are taken from the highest-numbered of those lanes.
- R9: Reset empties every arrival set and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_id | input | CORE_W | Number of this core, carried on global requests |
| active_warps | input | NUM_WARPS | Set of warps currently running |
| arr_valid | input | LANES | One arrival valid bit per lane |
| arr_bar_id | input | LANES x 32 | Barrier identifier per lane (bit 31 mode, low bits index) |
| arr_count | input | LANES x CNT_W | Expected participant count per lane |
| arr_wid | input | LANES x WID_W | Arriving warp number per lane |
| suspend | output | LANES | Stall the arriving warp of this lane |
| bar_err | output | LANES | Barrier index out of range on this lane |
| resume_mask | output | NUM_WARPS | Warps to unstall (one-cycle pulse) |
| gbar_req | output | NUM_BARRIERS | Global request per barrier (one-cycle pulse) |
| gbar_count | output | NUM_BARRIERS x CNT_W | Expected count of each global request |
| gbar_core | output | CORE_W | Core number accompanying global requests |

## Verification
`suspend` and `bar_err` are combinational: they are due in the cycle the arrival is driven, and the driver samples them 1 ns after it drives the lane inputs. `resume_mask`, `gbar_req`, `gbar_count` and `gbar_core` are due one clock edge after the completing arrival. The driver pushes one expected record for every cycle it drives, idle cycles included. The monitor pops that record 2 ns after the following rising edge, so each comparison lines up with exactly one edge of latency and also catches any pulse that lasts too long or comes too early.

// File: rtl/wbar_pkg.sv
package wbar_pkg;
  localparam int unsigned BAR_ID_W = 32;
  localparam int unsigned GLB_BIT  = 31;

  typedef enum logic {
    SYNC_LOCAL  = 1'b0,
    SYNC_GLOBAL = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/wbar_popcnt.sv
module wbar_popcnt #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 4
) (
  input  logic [IN_W-1:0]  vec,
  output logic [OUT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < IN_W; i++) cnt += OUT_W'(vec[i]);
  end
endmodule

// File: rtl/wbar_decode.sv
module wbar_decode
  import wbar_pkg::*;
#(
  parameter int unsigned NB    = 4,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic [BAR_ID_W-1:0] bar_id,
  input  logic [CNT_W-1:0]    count,
  output logic                take,
  output logic [IDX_W-1:0]    idx,
  output sync_mode_e          mode,
  output logic                err
);
  logic waits;
  logic in_range;

  // count of 0 or 1 never waits
  assign waits    = valid && (count >= CNT_W'(2));
  assign in_range = bar_id[GLB_BIT-1:0] < (GLB_BIT)'(NB);
  assign take     = waits && in_range;
  assign err      = waits && !in_range;
  assign idx      = bar_id[IDX_W-1:0];
  assign mode     = sync_mode_e'(bar_id[GLB_BIT]);

  // R1
  short_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && count < CNT_W'(2)) |-> (!take && !err));
endmodule

// File: rtl/wbar_slot.sv
module wbar_slot
  import wbar_pkg::*;
#(
  parameter int unsigned NW    = 8,
  parameter int unsigned LANES = 2,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned WID_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            hit,
  input  logic [LANES-1:0][WID_W-1:0] wid,
  input  logic [LANES-1:0][CNT_W-1:0] cnt,
  input  logic [LANES-1:0]            glb,
  input  logic [CNT_W-1:0]            active_n,
  output logic [NW-1:0]               rel_mask,
  output logic                        req,
  output logic [CNT_W-1:0]            req_cnt
);
  logic [NW-1:0]    arr_q;
  logic [NW-1:0]    arr_nxt;
  logic [CNT_W-1:0] tgt_cnt;
  logic [CNT_W-1:0] seen;
  logic [CNT_W-1:0] goal;
  logic             tgt_glb;
  logic             any_hit;
  logic             done;

  // merge every lane of this cycle; last lane sets target and mode
  always_comb begin
    arr_nxt = arr_q;
    tgt_cnt = '0;
    tgt_glb = 1'b0;
    any_hit = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l]) begin
        arr_nxt[wid[l]] = 1'b1;
        tgt_cnt         = cnt[l];
        tgt_glb         = glb[l];
        any_hit         = 1'b1;
      end
    end
  end

  wbar_popcnt #(.IN_W(NW), .OUT_W(CNT_W)) u_seen (.vec(arr_nxt), .cnt(seen));

  assign goal = tgt_glb ? active_n : tgt_cnt;
  assign done = any_hit && (seen == goal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_q    <= '0;
      rel_mask <= '0;
      req      <= 1'b0;
      req_cnt  <= '0;
    end else begin
      rel_mask <= '0;
      req      <= 1'b0;
      if (done) begin
        arr_q <= '0;
        if (tgt_glb) begin
          req     <= 1'b1;
          req_cnt <= tgt_cnt;
        end else begin
          rel_mask <= arr_nxt;
        end
      end else begin
        arr_q <= arr_nxt;
      end
    end
  end

  // R4
  rel_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_mask) |-> $past(|hit));
  // R5
  clear_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rel_mask) || req) |-> (arr_q == '0));
  // R6
  req_after_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(|(hit & glb)));
endmodule

// File: rtl/warp_barrier.sv
module warp_barrier
  import wbar_pkg::*;
#(
  parameter int unsigned NUM_WARPS    = 8,
  parameter int unsigned NUM_BARRIERS = 4,
  parameter int unsigned LANES        = 2,
  parameter int unsigned CORE_W       = 4,
  localparam int unsigned WID_W = $clog2(NUM_WARPS),
  localparam int unsigned CNT_W = $clog2(NUM_WARPS + 1),
  localparam int unsigned IDX_W = $clog2(NUM_BARRIERS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [CORE_W-1:0]                     core_id,
  input  logic [NUM_WARPS-1:0]                  active_warps,
  input  logic [LANES-1:0]                      arr_valid,
  input  logic [LANES-1:0][BAR_ID_W-1:0]        arr_bar_id,
  input  logic [LANES-1:0][CNT_W-1:0]           arr_count,
  input  logic [LANES-1:0][WID_W-1:0]           arr_wid,
  output logic [LANES-1:0]                      suspend,
  output logic [LANES-1:0]                      bar_err,
  output logic [NUM_WARPS-1:0]                  resume_mask,
  output logic [NUM_BARRIERS-1:0]               gbar_req,
  output logic [NUM_BARRIERS-1:0][CNT_W-1:0]    gbar_count,
  output logic [CORE_W-1:0]                     gbar_core
);
  logic [LANES-1:0]                   lane_take;
  logic [LANES-1:0][IDX_W-1:0]        lane_idx;
  logic [LANES-1:0]                   lane_glb;
  logic [NUM_BARRIERS-1:0][LANES-1:0] hit_m;
  logic [NUM_BARRIERS-1:0][NUM_WARPS-1:0] rel_m;
  logic [CNT_W-1:0]                   active_n;
  logic [CORE_W-1:0]                  core_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sync_mode_e mode_l;
    wbar_decode #(.NB(NUM_BARRIERS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (arr_valid[l]),
      .bar_id (arr_bar_id[l]),
      .count  (arr_count[l]),
      .take   (lane_take[l]),
      .idx    (lane_idx[l]),
      .mode   (mode_l),
      .err    (bar_err[l])
    );
    assign lane_glb[l] = (mode_l == SYNC_GLOBAL);
    assign suspend[l]  = lane_take[l];
  end

  wbar_popcnt #(.IN_W(NUM_WARPS), .OUT_W(CNT_W)) u_active (
    .vec (active_warps),
    .cnt (active_n)
  );

  for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_bar
    for (genvar l = 0; l < LANES; l++) begin : g_hit
      assign hit_m[b][l] = lane_take[l] && (lane_idx[l] == IDX_W'(b));
    end
    wbar_slot #(.NW(NUM_WARPS), .LANES(LANES), .CNT_W(CNT_W), .WID_W(WID_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit_m[b]),
      .wid      (arr_wid),
      .cnt      (arr_count),
      .glb      (lane_glb),
      .active_n (active_n),
      .rel_mask (rel_m[b]),
      .req      (gbar_req[b]),
      .req_cnt  (gbar_count[b])
    );
  end

  always_comb begin
    resume_mask = '0;
    for (int b = 0; b < NUM_BARRIERS; b++) resume_mask |= rel_m[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) core_q <= '0;
    else        core_q <= core_id;
  end
  assign gbar_core = core_q;

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_err & suspend) == '0);
  // R6
  glb_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gbar_req) |-> (gbar_core == $past(core_id)));
endmodule

// File: tb/warp_barrier_test.sv
module warp_barrier_test;
  localparam int NW = 8;
  localparam int NB = 4;
  localparam int P  = 2;
  localparam int CW = 4;
  localparam int CNT_W = 4;
  localparam int WID_W = 3;
  localparam logic [CW-1:0] CORE = 4'h5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] act = '1;
  logic [P-1:0] arr_valid = '0;
  logic [P-1:0][31:0] arr_bar_id = '0;
  logic [P-1:0][CNT_W-1:0] arr_count = '0;
  logic [P-1:0][WID_W-1:0] arr_wid = '0;
  logic [P-1:0] suspend, bar_err;
  logic [NW-1:0] resume_mask;
  logic [NB-1:0] gbar_req;
  logic [NB-1:0][CNT_W-1:0] gbar_count;
  logic [CW-1:0] gbar_core;

  always #5 clk = ~clk;

  warp_barrier #(.NUM_WARPS(NW), .NUM_BARRIERS(NB), .LANES(P), .CORE_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .core_id(CORE), .active_warps(act),
    .arr_valid(arr_valid), .arr_bar_id(arr_bar_id), .arr_count(arr_count), .arr_wid(arr_wid),
    .suspend(suspend), .bar_err(bar_err), .resume_mask(resume_mask),
    .gbar_req(gbar_req), .gbar_count(gbar_count), .gbar_core(gbar_core)
  );

  typedef struct {
    logic [NW-1:0] res;
    logic [NB-1:0] req;
    logic [NB-1:0][CNT_W-1:0] cnt;
    string tag;
  } exp_t;

  exp_t q[$];
  logic [NW-1:0] model[NB];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic step(input bit v0, input logic [31:0] id0, input int c0, input int w0,
                      input bit v1, input logic [31:0] id1, input int c1, input int w1,
                      input string tag);
    bit v[P];
    logic [31:0] id[P];
    int c[P];
    int w[P];
    logic [P-1:0] es, ee;
    exp_t it;
    v[0] = v0; id[0] = id0; c[0] = c0; w[0] = w0;
    v[1] = v1; id[1] = id1; c[1] = c1; w[1] = w1;
    @(negedge clk);
    for (int l = 0; l < P; l++) begin
      arr_valid[l]  = v[l];
      arr_bar_id[l] = id[l];
      arr_count[l]  = CNT_W'(c[l]);
      arr_wid[l]    = WID_W'(w[l]);
      es[l] = v[l] && c[l] >= 2 && id[l][30:0] < NB;
      ee[l] = v[l] && c[l] >= 2 && id[l][30:0] >= NB;
    end
    #1;
    chk(suspend == es, {tag, " suspend"}, 32'(suspend), 32'(es));
    chk(bar_err == ee, {tag, " bar_err"}, 32'(bar_err), 32'(ee));
    it.res = '0; it.req = '0; it.cnt = '0; it.tag = tag;
    for (int b = 0; b < NB; b++) begin
      logic [NW-1:0] nm;
      int tc;
      bit tg;
      bit hb;
      nm = model[b]; tc = 0; tg = 0; hb = 0;
      for (int l = 0; l < P; l++) begin
        if (es[l] && id[l][1:0] == 2'(b)) begin
          nm[w[l]] = 1'b1; tc = c[l]; tg = id[l][31]; hb = 1;
        end
      end
      if (hb && $countones(nm) == (tg ? $countones(act) : tc)) begin
        model[b] = '0;
        if (tg) begin it.req[b] = 1'b1; it.cnt[b] = CNT_W'(tc); end
        else it.res |= nm;
      end else begin
        model[b] = nm;
      end
    end
    q.push_back(it);
  endtask

  task automatic arrive(input logic [31:0] id, input int c, input int w, input string tag);
    step(1, id, c, w, 0, 0, 0, 0, tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    arr_valid = '0;
    for (int b = 0; b < NB; b++) model[b] = '0;
    repeat (2) @(negedge clk);
    // R9: outputs clear under reset
    chk(resume_mask == '0, "R9 resume", 32'(resume_mask), 0);
    chk(gbar_req == '0, "R9 gbar_req", 32'(gbar_req), 0);
    chk(suspend == '0, "R9 suspend", 32'(suspend), 0);
    rst_n = 1'b1;
  endtask

  // monitor: one record per driven cycle, one edge later
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk(resume_mask == it.res, {it.tag, " resume_mask"}, 32'(resume_mask), 32'(it.res));
        chk(gbar_req == it.req, {it.tag, " gbar_req"}, 32'(gbar_req), 32'(it.req));
        for (int b = 0; b < NB; b++) begin
          if (it.req[b]) begin
            chk(gbar_count[b] == it.cnt[b], {it.tag, " gbar_count"}, 32'(gbar_count[b]), 32'(it.cnt[b]));
            chk(gbar_core == CORE, {it.tag, " gbar_core"}, 32'(gbar_core), 32'(CORE));
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) model[b] = '0;
    do_reset();
    // R2 R4: local barrier 1, count 3
    arrive(32'd1, 3, 0, "R2 local first");
    arrive(32'd1, 3, 1, "R2 local second");
    arrive(32'd1, 3, 2, "R4 local final");
    idle("R4 pulse ends");
    // R5: fresh gathering on same barrier
    arrive(32'd1, 2, 3, "R5 fresh first");
    arrive(32'd1, 2, 4, "R5 fresh final");
    idle("R5 idle");
    // R1: count 1 passes through, leaves no trace
    arrive(32'd2, 1, 5, "R1 count one");
    arrive(32'd2, 0, 5, "R1 count zero");
    arrive(32'd2, 2, 6, "R1 after pass first");
    arrive(32'd2, 2, 7, "R1 after pass final");
    // R8: two lanes, same barrier, same cycle
    step(1, 32'd0, 2, 2, 1, 32'd0, 2, 5, "R8 dual arrival");
    idle("R8 idle");
    // R8: dual arrival where first lane alone would not complete
    arrive(32'd2, 3, 1, "R8 pre");
    step(1, 32'd2, 3, 3, 1, 32'd2, 3, 4, "R8 dual final");
    // R3 R6: global on barrier 3 with four active warps
    act = 8'h0F;
    arrive(32'h8000_0003, 2, 0, "R3 global first");
    arrive(32'h8000_0003, 2, 1, "R3 global count not enough");
    step(1, 32'h8000_0003, 2, 2, 1, 32'h8000_0003, 2, 3, "R6 global final");
    idle("R6 idle");
    act = 8'hFF;
    // R7: out-of-range index aliasing onto barrier 3
    arrive(32'd7, 2, 1, "R7 out of range");
    arrive(32'h0000_0103, 2, 2, "R7 high bits out of range");
    arrive(32'd3, 2, 0, "R7 barrier3 first");
    arrive(32'd3, 2, 6, "R7 barrier3 final");
    idle("R7 idle");
    // R9: reset drops a pending arrival
    arrive(32'd1, 2, 0, "R9 before reset");
    idle("R9 settle");
    do_reset();
    arrive(32'd1, 2, 1, "R9 after reset first");
    arrive(32'd1, 2, 2, "R9 after reset final");
    idle("R9 idle");
    idle("end");
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule